// File: doc/BRIEF.md
# Parallel Configuration Stream Loader

This block is the host-side driver for loading a configuration image into a target device through that device's parallel slave port. It waits for a start request and for the target to report that it can accept data. It then lowers the write-select line, lowers the active-low chip select one system clock later, and sends image words from a valid/ready input stream. Each word is captured by the target on one rising edge of a configuration clock that this block generates by dividing the system clock.

The stream side follows valid/ready rules. A word is taken in any system cycle where `s_valid` and `s_ready` are both high. `s_ready` is high only while loading, and only when the output holding register is empty and the configuration clock is low or about to fall. The source may hold `s_valid` low for as long as it likes. While no word is held, the configuration clock stops in its low phase, so the target never samples a stale word. `s_last` marks the final word of the image.

After the final word has been clocked out, the configuration clock runs freely until the target raises `done_in`. It then produces `POST_CYC` further rising edges. After that it stops low, releases chip select, and releases write-select one cycle later. If `done_in` stays low for `TIMEOUT_CYC` system cycles after the final word, an error flag is raised and the strobes are released without a finished pulse. `done_in` and `init_ready` are assumed to be synchronous to `clk`.

Top module: `cfg_stream_loader`

## Requirements
- R1: After reset `cfg_cs_n` and `cfg_wr_n` are 1, `cfg_clk` is 0, and `busy`, `finished`, `s_ready` and `timeout_err` are 0.
- R2: A `start` pulse seen in idle sets `busy` on the next cycle. No strobe moves and no clock edge is produced until `init_ready` is high.
- R3: `cfg_wr_n` goes low at least one system cycle before `cfg_cs_n` goes low. `cfg_wr_n` does not change while `cfg_cs_n` is low.
- R4: The target receives the stream words in order, one per rising `cfg_clk` edge, starting with the first rising edge after `cfg_cs_n` falls. `cfg_data` changes only while `cfg_clk` is low or at the system edge where it falls.
- R5: With an uninterrupted stream, consecutive data edges of `cfg_clk` are exactly `DIV` system cycles apart, with `DIV/2` cycles high.
- R6: When no stream word is held, `cfg_clk` stays low and produces no rising edge.
- R7: `s_ready` is high only while loading, when both strobes are low. A word transfers when `s_valid` and `s_ready` are both high, and the word flagged by `s_last` is the final one.
- R8: Once the final word is sent, `cfg_clk` keeps running until `done_in` is sampled high. Exactly `POST_CYC` rising edges occur at or after the first system edge that samples `done_in` high, and then `cfg_clk` stays low.
- R9: At the end, `cfg_cs_n` goes high while `cfg_clk` is low, and `cfg_wr_n` goes high one system cycle later.
- R10: `busy` stays high from start until the release completes. `finished` is a single-cycle pulse in the last busy cycle of a successful load.
- R11: If `done_in` is not seen within `TIMEOUT_CYC` system cycles after the final word's edge, `timeout_err` is set, both strobes are released and `finished` does not pulse. `timeout_err` clears at the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (accepted while idle) |
| init_ready | input | 1 | Target ready to accept configuration |
| s_data | input | DATA_W | Stream word |
| s_valid | input | 1 | Stream word valid |
| s_last | input | 1 | Stream word is the final image word |
| s_ready | output | 1 | Loader accepts the stream word |
| done_in | input | 1 | Target reports configuration complete |
| cfg_clk | output | 1 | Generated configuration clock |
| cfg_cs_n | output | 1 | Active-low chip select to target |
| cfg_wr_n | output | 1 | Write-select, low for writing |
| cfg_data | output | DATA_W | Data bus to target |
| busy | output | 1 | Load sequence in progress |
| finished | output | 1 | One-cycle pulse on successful completion |
| timeout_err | output | 1 | DONE not seen in time |

## Verification
The loader is driven with an unbroken stream, where the fixed edge spacing shows that the prefetch at the falling phase keeps up. It is also driven with a stream that pauses for many cycles between words, where a frozen edge count and a low clock show that the hold works and that no word is lost or repeated. A run that holds `init_ready` low at first separates the wait for the target from the strobe sequencing. A run in which `done_in` never rises separates the timeout path from the normal post-DONE count. A following run confirms that the error flag clears. Every run compares the captured words with the sent words and measures when the strobes move relative to each other.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_WRSEL,
    ST_LOAD,
    ST_DONEW,
    ST_POST,
    ST_RELCS,
    ST_RELWR
  } ld_state_t;
endpackage

// File: rtl/cfgld_clkgen.sv
module cfgld_clkgen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic cfg_clk,
  output logic rise_now,
  output logic fall_now
);
  localparam int HALF = DIV / 2;
  localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HW-1:0] hcnt;
  logic          clk_q;
  logic          at_end;

  assign at_end   = (hcnt == HW'(HALF - 1));
  // low phase advances only when run; high phase always completes
  assign rise_now = !clk_q && run && at_end;
  assign fall_now = clk_q && at_end;
  assign cfg_clk  = clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt  <= '0;
      clk_q <= 1'b0;
    end else if (!clk_q && !run) begin
      hcnt <= '0;
    end else if (at_end) begin
      hcnt  <= '0;
      clk_q <= !clk_q;
    end else begin
      hcnt <= hcnt + HW'(1);
    end
  end

  // R6: a stopped low phase stays low
  p_hold_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_q && !run) |=> !clk_q);
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import cfgld_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int POST_CYC    = 64,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              init_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  input  logic              done_in,
  input  logic              cfg_clk,
  input  logic              rise_now,
  input  logic              fall_now,
  output logic              run,
  output logic              cfg_cs_n,
  output logic              cfg_wr_n,
  output logic [DATA_W-1:0] cfg_data,
  output logic              busy,
  output logic              finished,
  output logic              timeout_err
);
  localparam int PW = $clog2(POST_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  ld_state_t         state;
  logic              have_q, last_q, err_q, cs_q, wr_q;
  logic [PW-1:0]     post_cnt;
  logic [TW-1:0]     tmo_cnt;
  logic [DATA_W-1:0] data_q;
  logic              take;

  assign s_ready = (state == ST_LOAD) && !have_q && (!cfg_clk || fall_now);
  assign take    = s_valid && s_ready;

  always_comb begin
    case (state)
      ST_LOAD:  run = have_q;
      ST_DONEW: run = 1'b1;
      ST_POST:  run = (post_cnt != PW'(POST_CYC));
      default:  run = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      have_q   <= 1'b0;
      last_q   <= 1'b0;
      err_q    <= 1'b0;
      cs_q     <= 1'b1;
      wr_q     <= 1'b1;
      post_cnt <= '0;
      tmo_cnt  <= '0;
      data_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          err_q <= 1'b0;
          state <= ST_INIT;
        end
        ST_INIT: if (init_ready) begin
          wr_q  <= 1'b0;
          state <= ST_WRSEL;
        end
        ST_WRSEL: begin
          cs_q   <= 1'b0;
          have_q <= 1'b0;
          state  <= ST_LOAD;
        end
        ST_LOAD: begin
          if (take) begin
            data_q <= s_data;
            have_q <= 1'b1;
            last_q <= s_last;
          end else if (rise_now) begin
            have_q <= 1'b0;
            if (last_q) begin
              tmo_cnt <= '0;
              state   <= ST_DONEW;
            end
          end
        end
        ST_DONEW: begin
          if (done_in) begin
            post_cnt <= rise_now ? PW'(1) : PW'(0);
            state    <= ST_POST;
          end else if (tmo_cnt == TW'(TIMEOUT_CYC - 1)) begin
            err_q <= 1'b1;
            state <= ST_RELCS;
          end else begin
            tmo_cnt <= tmo_cnt + TW'(1);
          end
        end
        ST_POST: begin
          if (post_cnt == PW'(POST_CYC)) state <= ST_RELCS;
          else if (rise_now)              post_cnt <= post_cnt + PW'(1);
        end
        ST_RELCS: if (!cfg_clk) begin
          cs_q  <= 1'b1;
          state <= ST_RELWR;
        end
        ST_RELWR: begin
          wr_q  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cfg_cs_n    = cs_q;
  assign cfg_wr_n    = wr_q;
  assign cfg_data    = data_q;
  assign busy        = (state != ST_IDLE);
  assign finished    = (state == ST_RELWR) && !err_q;
  assign timeout_err = err_q;

  // R3: write-select already low when chip select falls
  p_wr_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> $past(!wr_q));
  // R3: write-select frozen while selected
  p_wr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |-> $stable(wr_q));
  // R4: data moves only in the low phase
  p_data_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> !cfg_clk);
  // R6: a loading rise always has a held word behind it
  p_no_empty_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_clk) && $past(state == ST_LOAD)) |-> $past(have_q));
  // R7: stream accepted only with both strobes active
  p_ready_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (!cs_q && !wr_q));
  // R8: clock edges only while selected
  p_rise_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk) |-> !cs_q);
  // R9: write-select released only after chip select
  p_rel_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_q) |-> $past(cs_q));
  // R11: an error run never reports success
  p_err_nofin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> !finished);
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader #(
  parameter int DATA_W      = 8,
  parameter int DIV         = 4,
  parameter int POST_CYC    = 64,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              init_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  input  logic              done_in,
  output logic              cfg_clk,
  output logic              cfg_cs_n,
  output logic              cfg_wr_n,
  output logic [DATA_W-1:0] cfg_data,
  output logic              busy,
  output logic              finished,
  output logic              timeout_err
);
  generate
    if (DATA_W != 8 && DATA_W != 16 && DATA_W != 32) begin : g_bad_width
      $error("DATA_W must be 8, 16 or 32");
    end
    if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
      $error("DIV must be even and at least 2");
    end
  endgenerate

  logic run, rise_now, fall_now, clk_int;

  cfgld_clkgen #(.DIV(DIV)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .cfg_clk  (clk_int),
    .rise_now (rise_now),
    .fall_now (fall_now)
  );

  cfgld_seq #(
    .DATA_W      (DATA_W),
    .POST_CYC    (POST_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .init_ready  (init_ready),
    .s_data      (s_data),
    .s_valid     (s_valid),
    .s_last      (s_last),
    .s_ready     (s_ready),
    .done_in     (done_in),
    .cfg_clk     (clk_int),
    .rise_now    (rise_now),
    .fall_now    (fall_now),
    .run         (run),
    .cfg_cs_n    (cfg_cs_n),
    .cfg_wr_n    (cfg_wr_n),
    .cfg_data    (cfg_data),
    .busy        (busy),
    .finished    (finished),
    .timeout_err (timeout_err)
  );

  assign cfg_clk = clk_int;
endmodule

// File: tb/tb_cfg_stream_loader.sv
`timescale 1ns/1ps
module tb_cfg_stream_loader;
  localparam int DW   = 16;
  localparam int DIV  = 4;
  localparam int POST = 8;
  localparam int TMO  = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, init_ready = 0, s_valid = 0, s_last = 0, done_in = 0;
  logic [DW-1:0] s_data = '0;
  logic s_ready, cfg_clk, cfg_cs_n, cfg_wr_n, busy, finished, timeout_err;
  logic [DW-1:0] cfg_data;

  always #2 clk = ~clk;  // 250 MHz

  cfg_stream_loader #(.DATA_W(DW), .DIV(DIV), .POST_CYC(POST), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .init_ready(init_ready),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .done_in(done_in), .cfg_clk(cfg_clk), .cfg_cs_n(cfg_cs_n), .cfg_wr_n(cfg_wr_n),
    .cfg_data(cfg_data), .busy(busy), .finished(finished), .timeout_err(timeout_err)
  );

  int tests = 0, fails = 0;
  int rise_tot, post_r, exp_n, fin_cnt, fin_bad, wr_glitch;
  realtime last_t, min_int, max_int, t_wrf, t_csf, t_csr, t_wrr;
  logic [DW-1:0] cap [0:31];

  function automatic logic [DW-1:0] word_of(input int i, input int seed);
    return DW'(seed) ^ DW'(i * 16'h1357);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // target-side model: capture on rising configuration clock while selected
  always @(posedge cfg_clk) if (rst_n && !cfg_cs_n) begin
    if (rise_tot < exp_n && rise_tot < 32) cap[rise_tot] = cfg_data;
    if (rise_tot > 0 && rise_tot < exp_n) begin
      if ($realtime - last_t < min_int) min_int = $realtime - last_t;
      if ($realtime - last_t > max_int) max_int = $realtime - last_t;
    end
    last_t = $realtime;
    if (done_in) post_r++;
    rise_tot++;
  end
  always @(negedge cfg_wr_n) t_wrf = $realtime;
  always @(negedge cfg_cs_n) t_csf = $realtime;
  always @(posedge cfg_cs_n) t_csr = $realtime;
  always @(posedge cfg_wr_n) t_wrr = $realtime;
  always @(cfg_wr_n) if (rst_n && !cfg_cs_n) wr_glitch++;
  always @(posedge clk) if (rst_n && finished) begin
    fin_cnt++;
    if (!busy) fin_bad++;
  end

  task automatic push(input logic [DW-1:0] w, input bit l);
    bit got;
    s_valid = 1; s_data = w; s_last = l;
    forever begin
      got = s_ready;
      @(negedge clk);
      if (got) break;
    end
    s_valid = 0; s_last = 0;
  endtask

  task automatic run_load(input int n, input int gap, input int dly, input bit nodone,
                          input bit hold_init, input int seed);
    int r0;
    rise_tot = 0; post_r = 0; exp_n = n; fin_cnt = 0; fin_bad = 0; wr_glitch = 0;
    min_int = 1e9; max_int = 0;
    t_wrf = 0; t_csf = 0; t_csr = 0; t_wrr = 0;
    done_in = 0;
    init_ready = !hold_init;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy == 1, "R2 busy after start", busy, 1);
    chk(timeout_err == 0, "R11 error cleared on start", timeout_err, 0);
    if (hold_init) begin
      repeat (20) @(negedge clk);
      chk(cfg_cs_n && cfg_wr_n && rise_tot == 0, "R2 idle strobes while target not ready",
          {cfg_cs_n, cfg_wr_n}, 3);
      chk(s_ready == 0, "R7 no ready before select", s_ready, 0);
      init_ready = 1;
    end
    fork
      begin
        for (int i = 0; i < n; i++) begin
          if (gap > 0 && i > 0) begin
            repeat (6) @(negedge clk);
            r0 = rise_tot;
            repeat (gap - 6) @(negedge clk);
            chk(rise_tot == r0 && cfg_clk == 0, "R6 clock held while stream empty", rise_tot, r0);
          end
          push(word_of(i, seed), i == n - 1);
        end
      end
      begin
        if (!nodone) begin
          wait (rise_tot >= n + dly);
          @(negedge clk); done_in = 1;
        end
      end
    join
    for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
    @(negedge clk);
    chk(busy == 0, "R10 busy ends", busy, 0);
    chk(t_wrf < t_csf, "R3 write-select before chip select", int'(t_wrf), int'(t_csf));
    chk(wr_glitch == 0, "R3 write-select steady while selected", wr_glitch, 0);
    for (int i = 0; i < n; i++)
      chk(cap[i] == word_of(i, seed), "R4 word order", cap[i], word_of(i, seed));
    chk(t_csr < t_wrr && t_wrr - t_csr == 4.0, "R9 release order", int'(t_wrr - t_csr), 4);
    chk(cfg_cs_n && cfg_wr_n && !cfg_clk, "R9 idle after release",
        {cfg_cs_n, cfg_wr_n, cfg_clk}, 6);
    chk(s_ready == 0, "R7 ready low after load", s_ready, 0);
    if (nodone) begin
      chk(timeout_err == 1, "R11 timeout flagged", timeout_err, 1);
      chk(fin_cnt == 0, "R11 no finished pulse", fin_cnt, 0);
    end else begin
      chk(timeout_err == 0, "R11 no timeout", timeout_err, 0);
      chk(post_r == POST, "R8 post-DONE edges", post_r, POST);
      chk(rise_tot == n + dly + POST, "R8 clock runs until DONE", rise_tot, n + dly + POST);
      chk(fin_cnt == 1 && fin_bad == 0, "R10 single finished pulse", fin_cnt, 1);
    end
    if (gap == 0 && n > 1)
      chk(min_int == 16.0 && max_int == 16.0, "R5 edge spacing", int'(max_int), 16);
    done_in = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(cfg_cs_n && cfg_wr_n && !cfg_clk, "R1 strobes at reset", {cfg_cs_n, cfg_wr_n, cfg_clk}, 6);
    chk(!busy && !finished && !s_ready && !timeout_err, "R1 status at reset",
        {busy, finished, s_ready, timeout_err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && cfg_cs_n && !cfg_clk, "R1 idle after reset release", busy, 0);
  endtask

  task automatic t_continuous(); run_load(10, 0, 3, 0, 0, 16'hA55A); endtask  // R4 R5 R8
  task automatic t_gapped();     run_load(5, 14, 0, 0, 0, 16'h3C0F); endtask  // R6
  task automatic t_wait_init();  run_load(4, 0, 1, 0, 1, 16'h0F0F); endtask  // R2
  task automatic t_timeout();    run_load(3, 0, 0, 1, 0, 16'h1234); endtask  // R11
  task automatic t_recover();    run_load(6, 0, 5, 0, 0, 16'hBEEF); endtask  // R11 clear

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_continuous();
    t_gapped();
    t_wait_init();
    t_timeout();
    t_recover();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule